// File: doc/BRIEF.md
# Segmented Register Bus Multiplexer

This block sits behind a host memory interface and steers each 32-bit register access to one of several peripheral cores. The word address is decoded in two stages: the upper bits pick a segment, one segment per kind of core (hash, random number, cipher), and the middle bits pick a core slot within that segment. The low byte then selects a register inside the chosen core. Slot 0 of the hash segment does not hold a hash engine. It holds the board-information bank, which contains a fixed board type, a fixed build version and one general-purpose register that software can read and write.

Every slot is switched in or out at build time by an enable mask per segment. A slot that is switched out, a core number past the end of its segment, a register offset no core implements, and the whole reserved fourth segment all behave as empty space: writes there are dropped, reads return zero, and no error is flagged. The cores return read data combinationally. The block registers that data, so every read has a fixed latency of one clock. The random-number and cipher segments, and the hash slots above 0, contain simple placeholder cores. Each one has an identification word and a scratch register, so that every address bit can be exercised.

Top module: `regbus_mux`

## Requirements
- R1: The 17-bit word address is split into a segment field in bits [16:15] (0 hash, 1 random number, 2 cipher, 3 reserved), a core field in bits [14:8] and a register field in bits [7:0].
- R2: A read (cs high, we low) sampled at a rising edge presents its data on rdata right after that edge. After any edge where no read is sampled, rdata is zero.
- R3: Hash core 0 returns the BOARD_TYPE parameter at register 0 and the BUILD_VERSION parameter at register 1. Writes to either register are ignored.
- R4: Hash core 0 register 2 is a read/write general-purpose register that resets to zero.
- R5: Every other enabled slot is a placeholder core. Register 0 reads the constant ID_BASE + segment*256 + core and ignores writes. Register 1 is a read/write scratch register that resets to zero.
- R6: A slot whose bit in its segment's enable mask is 0 reads zero at every register, and writes to it change no other register.
- R7: Core numbers at or beyond a segment's slot count, and register offsets a core does not implement, read zero and drop writes.
- R8: Every address in the reserved segment 3 reads zero, and writes there change no register.
- R9: A write takes effect only at a rising edge where cs and we are both high. With we high and cs low, nothing changes.
- R10: Each writable register is reached only through its own address. A write to one address never changes what any other address reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 17 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
The hardest condition to reach is aliasing. A decode bug can make two addresses share one storage cell, and nothing shows it until a write lands on one address and the other is read back. To catch this, the bench first writes a distinct value derived from the address to every address in a sweep. That sweep covers all four segments, core numbers past each segment's end, disabled slots, and both implemented and unimplemented register offsets. It then reads the whole sweep back and compares each value against a model built only from the enable masks. A strobe with we high and cs low is also driven onto live scratch registers, so that a write which ignores cs would show up.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
   localparam int ADDR_W = 17;
   localparam int SEG_W  = 2;
   localparam int REG_W  = 8;
   localparam int CORE_W = ADDR_W - SEG_W - REG_W;
   localparam int DATA_W = 32;

   typedef enum logic [SEG_W-1:0] {
      SEG_HASH   = 2'd0,
      SEG_RNG    = 2'd1,
      SEG_CIPHER = 2'd2,
      SEG_RSVD   = 2'd3
   } seg_e;
endpackage

// File: rtl/regbus_board_bank.sv
module regbus_board_bank
   import regbus_pkg::*;
#(
   parameter logic [DATA_W-1:0] BOARD_TYPE    = 32'h0,
   parameter logic [DATA_W-1:0] BUILD_VERSION = 32'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  reg_idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_data
);
   localparam logic [REG_W-1:0] IDX_TYPE = REG_W'(0);
   localparam logic [REG_W-1:0] IDX_VER  = REG_W'(1);
   localparam logic [REG_W-1:0] IDX_GP   = REG_W'(2);

   logic [DATA_W-1:0] gp_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                          gp_q <= '0;
      else if (wr_en && reg_idx == IDX_GP) gp_q <= wdata;
   end

   always_comb begin
      unique case (reg_idx)
         IDX_TYPE: rd_data = BOARD_TYPE;
         IDX_VER:  rd_data = BUILD_VERSION;
         IDX_GP:   rd_data = gp_q;
         default:  rd_data = '0;
      endcase
   end

   // R4: general-purpose register moves only on its own write
   a_r4_gp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && reg_idx == IDX_GP) |=> $stable(gp_q));
endmodule

// File: rtl/regbus_stub_core.sv
module regbus_stub_core
   import regbus_pkg::*;
#(
   parameter logic [DATA_W-1:0] ID_VALUE = 32'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  reg_idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_data
);
   localparam logic [REG_W-1:0] IDX_ID      = REG_W'(0);
   localparam logic [REG_W-1:0] IDX_SCRATCH = REG_W'(1);

   logic [DATA_W-1:0] scratch_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                               scratch_q <= '0;
      else if (wr_en && reg_idx == IDX_SCRATCH) scratch_q <= wdata;
   end

   always_comb begin
      unique case (reg_idx)
         IDX_ID:      rd_data = ID_VALUE;
         IDX_SCRATCH: rd_data = scratch_q;
         default:     rd_data = '0;
      endcase
   end

   // R5: scratch register moves only on its own write
   a_r5_scratch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && reg_idx == IDX_SCRATCH) |=> $stable(scratch_q));
endmodule

// File: rtl/regbus_segment.sv
module regbus_segment
   import regbus_pkg::*;
#(
   parameter int                  NCORES        = 2,
   parameter logic [NCORES-1:0]   EN_MASK       = '1,
   parameter bit                  HAS_BOARD     = 1'b0,
   parameter int                  SEG_ID        = 0,
   parameter logic [DATA_W-1:0]   ID_BASE       = 32'h0,
   parameter logic [DATA_W-1:0]   BOARD_TYPE    = 32'h0,
   parameter logic [DATA_W-1:0]   BUILD_VERSION = 32'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seg_hit,
   input  logic              wr,
   input  logic [CORE_W-1:0] core_idx,
   input  logic [REG_W-1:0]  reg_idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_data
);
   if (NCORES < 1 || NCORES > (1 << CORE_W)) begin : g_bad_count
      $error("regbus_segment: NCORES out of range");
   end

   logic [DATA_W-1:0] slot_rd [NCORES];
   logic [NCORES-1:0] slot_hit;

   for (genvar i = 0; i < NCORES; i++) begin : g_slot
      assign slot_hit[i] = seg_hit && (core_idx == CORE_W'(i));
      if (!EN_MASK[i]) begin : g_off
         assign slot_rd[i] = '0;
      end else if (HAS_BOARD && i == 0) begin : g_board
         regbus_board_bank #(
            .BOARD_TYPE    (BOARD_TYPE),
            .BUILD_VERSION (BUILD_VERSION)
         ) i_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr && slot_hit[i]),
            .reg_idx (reg_idx),
            .wdata   (wdata),
            .rd_data (slot_rd[i])
         );
      end else begin : g_stub
         regbus_stub_core #(
            .ID_VALUE (ID_BASE + DATA_W'(SEG_ID * 256 + i))
         ) i_stub (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr && slot_hit[i]),
            .reg_idx (reg_idx),
            .wdata   (wdata),
            .rd_data (slot_rd[i])
         );
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NCORES; i++) begin
         if (slot_hit[i]) rd_data = rd_data | slot_rd[i];
      end
   end

   // R1: at most one slot is addressed at a time
   a_r1_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot_hit));
endmodule

// File: rtl/regbus_mux.sv
module regbus_mux
   import regbus_pkg::*;
#(
   parameter int                      HASH_CORES    = 4,
   parameter logic [HASH_CORES-1:0]   HASH_EN       = 4'b1011,
   parameter int                      RNG_CORES     = 2,
   parameter logic [RNG_CORES-1:0]    RNG_EN        = 2'b11,
   parameter int                      CIPHER_CORES  = 2,
   parameter logic [CIPHER_CORES-1:0] CIPHER_EN     = 2'b01,
   parameter logic [31:0]             BOARD_TYPE    = 32'hB0A2_0001,
   parameter logic [31:0]             BUILD_VERSION = 32'h0002_0015,
   parameter logic [31:0]             ID_BASE       = 32'hC0DE_0000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cs,
   input  logic        we,
   input  logic [16:0] addr,
   input  logic [31:0] wdata,
   output logic [31:0] rdata
);
   if (ADDR_W != 17 || DATA_W != 32) begin : g_bad_bus
      $error("regbus_mux: package widths do not match the port list");
   end

   localparam int NSEG = 3;

   seg_e              seg;
   logic [CORE_W-1:0] core_idx;
   logic [REG_W-1:0]  reg_idx;
   logic              wr;
   logic              rd;
   logic [NSEG-1:0]   seg_hit;
   logic [DATA_W-1:0] seg_rd [NSEG];
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] rdata_q;

   assign seg      = seg_e'(addr[ADDR_W-1 -: SEG_W]);
   assign core_idx = addr[REG_W +: CORE_W];
   assign reg_idx  = addr[REG_W-1:0];
   assign wr       = cs && we;
   assign rd       = cs && !we;

   assign seg_hit[0] = (seg == SEG_HASH);
   assign seg_hit[1] = (seg == SEG_RNG);
   assign seg_hit[2] = (seg == SEG_CIPHER);

   regbus_segment #(
      .NCORES (HASH_CORES), .EN_MASK (HASH_EN), .HAS_BOARD (1'b1),
      .SEG_ID (0), .ID_BASE (ID_BASE),
      .BOARD_TYPE (BOARD_TYPE), .BUILD_VERSION (BUILD_VERSION)
   ) i_seg_hash (
      .clk (clk), .rst_n (rst_n), .seg_hit (seg_hit[0]), .wr (wr),
      .core_idx (core_idx), .reg_idx (reg_idx), .wdata (wdata),
      .rd_data (seg_rd[0])
   );

   regbus_segment #(
      .NCORES (RNG_CORES), .EN_MASK (RNG_EN), .HAS_BOARD (1'b0),
      .SEG_ID (1), .ID_BASE (ID_BASE),
      .BOARD_TYPE (BOARD_TYPE), .BUILD_VERSION (BUILD_VERSION)
   ) i_seg_rng (
      .clk (clk), .rst_n (rst_n), .seg_hit (seg_hit[1]), .wr (wr),
      .core_idx (core_idx), .reg_idx (reg_idx), .wdata (wdata),
      .rd_data (seg_rd[1])
   );

   regbus_segment #(
      .NCORES (CIPHER_CORES), .EN_MASK (CIPHER_EN), .HAS_BOARD (1'b0),
      .SEG_ID (2), .ID_BASE (ID_BASE),
      .BOARD_TYPE (BOARD_TYPE), .BUILD_VERSION (BUILD_VERSION)
   ) i_seg_cipher (
      .clk (clk), .rst_n (rst_n), .seg_hit (seg_hit[2]), .wr (wr),
      .core_idx (core_idx), .reg_idx (reg_idx), .wdata (wdata),
      .rd_data (seg_rd[2])
   );

   always_comb begin
      rd_mux = '0;
      for (int s = 0; s < NSEG; s++) begin
         if (seg_hit[s]) rd_mux = rd_mux | seg_rd[s];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  rdata_q <= '0;
      else if (rd) rdata_q <= rd_mux;
      else         rdata_q <= '0;
   end

   assign rdata = rdata_q;

   // R2: no read sampled means zero on the following cycle
   a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !(cs && !we) |=> rdata == '0);

   // R8: reserved segment reads zero
   a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && !we && addr[16:15] == 2'd3) |=> rdata == '0);

   // R3: board type appears one cycle after a read of address 0
   a_r3_board_type: assert property (@(posedge clk) disable iff (!rst_n)
      (HASH_EN[0] && cs && !we && addr == 17'd0) |=> rdata == BOARD_TYPE);
endmodule

// File: tb/test_regbus_mux.sv
module test_regbus_mux;
   localparam time CLK_PERIOD = 10ns;
   localparam logic [3:0]  H_EN = 4'b1011;
   localparam logic [1:0]  R_EN = 2'b11;
   localparam logic [1:0]  C_EN = 2'b01;
   localparam logic [31:0] BT   = 32'hB0A2_0001;
   localparam logic [31:0] BV   = 32'h0002_0015;
   localparam logic [31:0] IDB  = 32'hC0DE_0000;
   localparam int NCORE_SWEEP = 6;
   localparam int NREG_SWEEP  = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs = 1'b0;
   logic        we = 1'b0;
   logic [16:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [31:0] store [4][NCORE_SWEEP];

   always #(CLK_PERIOD/2) clk = ~clk;

   regbus_mux i_regbus_mux (
      .clk (clk), .rst_n (rst_n), .cs (cs), .we (we),
      .addr (addr), .wdata (wdata), .rdata (rdata)
   );

   function automatic int reg_of(input int k);
      int tbl [NREG_SWEEP] = '{0, 1, 2, 3, 255};
      return tbl[k];
   endfunction

   function automatic bit slot_on(input int s, input int c);
      case (s)
         0: return (c < 4) && H_EN[c];
         1: return (c < 2) && R_EN[c];
         2: return (c < 2) && C_EN[c];
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [16:0] mk_addr(input int s, input int c, input int r);
      return 17'((s << 15) | (c << 8) | r);
   endfunction

   function automatic logic [31:0] pat(input int s, input int c, input int r);
      return 32'h5A00_0000 ^ 32'((s << 20) | (c << 12) | (r << 1) | 1);
   endfunction

   function automatic logic [31:0] model(input int s, input int c, input int r);
      if (!slot_on(s, c)) return '0;
      if (s == 0 && c == 0) begin
         if (r == 0) return BT;
         if (r == 1) return BV;
         if (r == 2) return store[s][c];
         return '0;
      end
      if (r == 0) return IDB + 32'(s * 256 + c);
      if (r == 1) return store[s][c];
      return '0;
   endfunction

   function automatic bit writable(input int s, input int c, input int r);
      if (!slot_on(s, c)) return 1'b0;
      if (s == 0 && c == 0) return r == 2;
      return r == 1;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, act, exp);
      end
   endtask

   task automatic bus_write(input logic [16:0] a, input logic [31:0] d, input logic c_s);
      @(negedge clk);
      cs = c_s; we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      cs = 1'b0; we = 1'b0;
   endtask

   task automatic bus_read(input logic [16:0] a, output logic [31:0] d);
      @(negedge clk);
      cs = 1'b1; we = 1'b0; addr = a;
      @(negedge clk);
      d = rdata;
      cs = 1'b0;
   endtask

   initial begin
      logic [31:0] v;
      for (int s = 0; s < 4; s++)
         for (int c = 0; c < NCORE_SWEEP; c++) store[s][c] = '0;
      repeat (3) @(negedge clk);
      check("R2 reset", rdata, '0);
      rst_n = 1'b1;

      // reset values across the sweep: R3 R4 R5 R6 R7 R8
      for (int s = 0; s < 4; s++)
         for (int c = 0; c < NCORE_SWEEP; c++)
            for (int k = 0; k < NREG_SWEEP; k++) begin
               bus_read(mk_addr(s, c, reg_of(k)), v);
               check("R1/R3/R4/R5/R6/R7/R8 reset sweep", v, model(s, c, reg_of(k)));
            end

      // R2: one idle cycle after a read gives zero
      bus_read(17'd0, v);
      @(negedge clk);
      check("R2 idle zero", rdata, '0);

      // R9: cs low with we high must not write
      bus_write(mk_addr(1, 0, 1), 32'hDEAD_BEEF, 1'b0);
      bus_write(mk_addr(0, 0, 2), 32'hDEAD_BEEF, 1'b0);
      bus_read(mk_addr(1, 0, 1), v);
      check("R9 no cs", v, '0);
      bus_read(mk_addr(0, 0, 2), v);
      check("R9 no cs gp", v, '0);

      // R10: write a distinct pattern to every swept address
      for (int s = 0; s < 4; s++)
         for (int c = 0; c < NCORE_SWEEP; c++)
            for (int k = 0; k < NREG_SWEEP; k++) begin
               bus_write(mk_addr(s, c, reg_of(k)), pat(s, c, reg_of(k)), 1'b1);
               if (writable(s, c, reg_of(k))) store[s][c] = pat(s, c, reg_of(k));
            end

      for (int s = 0; s < 4; s++)
         for (int c = 0; c < NCORE_SWEEP; c++)
            for (int k = 0; k < NREG_SWEEP; k++) begin
               bus_read(mk_addr(s, c, reg_of(k)), v);
               check("R10/R3/R5/R6/R7/R8 write sweep", v, model(s, c, reg_of(k)));
            end

      // R4: general-purpose register read back and reset
      bus_write(mk_addr(0, 0, 2), 32'h1234_5678, 1'b1);
      bus_read(mk_addr(0, 0, 2), v);
      check("R4 gp rw", v, 32'h1234_5678);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      bus_read(mk_addr(0, 0, 2), v);
      check("R4 gp reset", v, '0);
      bus_read(mk_addr(2, 0, 1), v);
      check("R5 scratch reset", v, '0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule